// File: doc/BRIEF.md
# Dual-Read Register File with Byte-Merge Output

This block is a small synchronous register file: sixteen words of sixteen bits, with one write port and two read ports that all work in the same clock cycle. Writes are registered on the rising clock edge. Both reads are combinational lookups into the registered array, so a read that names the word being written in that cycle still sees the value held before the edge.

After the two read ports sits a byte-merge stage. It builds one output word from the upper byte of the first read port and the lower byte of the second. A swap input exchanges the two bytes of that word, so a 16-bit value stored across two neighbouring words can be returned aligned. Both read-port words also leave the block as they are, next to the merged word.

Top module: `dual_read_regfile`

## Requirements
- R1: A synchronous active-high reset clears every word to zero. A write requested in a reset cycle is not stored.
- R2: When `wr_en` is 1 at a rising clock edge outside reset, `wr_data` is stored at `wr_addr` and is visible on any read port that selects that word from the next cycle on.
- R3: When `wr_en` is 0 at a rising edge, no stored word changes, whatever `wr_addr` and `wr_data` hold.
- R4: The two read ports and the write port are independent. Each read port returns the word at its own address in the same cycle, while a write to another word is in progress.
- R5: A read port whose address equals `wr_addr` during a write returns the word held before that write. The new value appears one cycle later.
- R6: With `swap` at 0, `merged_data[15:8]` equals `rd_a_data[15:8]` and `merged_data[7:0]` equals `rd_b_data[7:0]`.
- R7: With `swap` at 1, `merged_data[15:8]` equals `rd_b_data[7:0]` and `merged_data[7:0]` equals `rd_a_data[15:8]`.
- R8: When both read addresses are equal, both read ports return the same word, and the merged word is built from that word's two bytes as in R6 and R7.
- R9: `rd_a_data` and `rd_b_data` are the stored words without any byte change, whatever `swap` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 4 | Word written |
| wr_data | input | 16 | Value written |
| rd_a_addr | input | 4 | Address for read port A |
| rd_b_addr | input | 4 | Address for read port B |
| swap | input | 1 | 0: straight merge, 1: bytes exchanged |
| rd_a_data | output | 16 | Raw word from read port A |
| rd_b_data | output | 16 | Raw word from read port B |
| merged_data | output | 16 | Merged word built from both ports |

## Verification
The bench targets a read whose address matches a write in the same cycle. A design that bypassed the write data to the read port would show the new value one cycle early. It writes with `wr_en` low and with reset high, then reads those words back, which exposes a store that ignored the enable or lost priority to the write. It sets the read addresses equal, and it toggles `swap` over words whose upper and lower bytes differ. A merge that took the wrong byte, or did not exchange the bytes, would give a mismatch that shows up even though both raw ports are correct.

// File: rtl/rf_pkg.sv
package rf_pkg;
    typedef enum logic {
        MERGE_STRAIGHT = 1'b0,
        MERGE_SWAPPED  = 1'b1
    } merge_mode_e;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int WORDS = 16,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [WORDS-1:0][WIDTH-1:0]  words_o
);
    typedef struct packed {
        logic [WORDS-1:0][WIDTH-1:0] words;
    } store_t;

    store_t          state_d, state_q;
    logic [WORDS-1:0] row_sel_d;

    // One write select per row.
    always_comb begin
        row_sel_d          = '0;
        row_sel_d[wr_addr] = wr_en;
    end

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.words = '0;
        end else begin
            for (int w = 0; w < WORDS; w++) begin
                if (row_sel_d[w]) begin
                    state_d.words[w] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign words_o = state_q.words;
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int WORDS = 16,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic [WORDS-1:0][WIDTH-1:0] words_i,
    input  logic [AW-1:0]               addr_i,
    output logic [WIDTH-1:0]            data_o
);
    // Combinational lookup of the registered array (old value during a write).
    always_comb begin
        data_o = words_i[addr_i];
    end
endmodule

// File: rtl/rf_byte_merge.sv
module rf_byte_merge
    import rf_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] hi_src_i,
    input  logic [WIDTH-1:0] lo_src_i,
    input  logic             swap_i,
    output logic [WIDTH-1:0] merged_o
);
    localparam int HALF = WIDTH / 2;

    merge_mode_e       mode_d;
    logic [HALF-1:0]   upper_d, lower_d;

    always_comb begin
        mode_d  = merge_mode_e'(swap_i);
        upper_d = hi_src_i[WIDTH-1:HALF];
        lower_d = lo_src_i[HALF-1:0];
        case (mode_d)
            MERGE_SWAPPED: merged_o = {lower_d, upper_d};
            default:       merged_o = {upper_d, lower_d};
        endcase
    end
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
    parameter int WORDS = 16,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_a_addr,
    input  logic [AW-1:0]    rd_b_addr,
    input  logic             swap,
    output logic [WIDTH-1:0] rd_a_data,
    output logic [WIDTH-1:0] rd_b_data,
    output logic [WIDTH-1:0] merged_data
);
    localparam int NUM_RD = 2;

    logic [WORDS-1:0][WIDTH-1:0] words_q;
    logic [NUM_RD-1:0][AW-1:0]    rd_addr_arr;
    logic [NUM_RD-1:0][WIDTH-1:0] rd_data_arr;

    assign rd_addr_arr[0] = rd_a_addr;
    assign rd_addr_arr[1] = rd_b_addr;

    rf_storage #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .words_o (words_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_rd (
            .words_i (words_q),
            .addr_i  (rd_addr_arr[p]),
            .data_o  (rd_data_arr[p])
        );
    end

    rf_byte_merge #(.WIDTH(WIDTH)) u_merge (
        .hi_src_i (rd_data_arr[0]),
        .lo_src_i (rd_data_arr[1]),
        .swap_i   (swap),
        .merged_o (merged_data)
    );

    assign rd_a_data = rd_data_arr[0];
    assign rd_b_data = rd_data_arr[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int WIDTH = 16,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic [AW-1:0]    rd_a_addr,
    input logic [AW-1:0]    rd_b_addr,
    input logic             swap,
    input logic [WIDTH-1:0] rd_a_data,
    input logic [WIDTH-1:0] rd_b_data,
    input logic [WIDTH-1:0] merged_data
);
    localparam int HALF = WIDTH / 2;

    assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_a_addr == wr_addr) |=>
            ((rd_a_addr == $past(rd_a_addr)) -> (rd_a_data == $past(wr_data))));

    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$isunknown(rd_b_addr)) |=>
            ((rd_b_addr == $past(rd_b_addr)) -> $stable(rd_b_data)));

    assert_straight_merge_R6: assert property (@(posedge clk) disable iff (rst)
        !swap |-> (merged_data[WIDTH-1:HALF] == rd_a_data[WIDTH-1:HALF] &&
                   merged_data[HALF-1:0]     == rd_b_data[HALF-1:0]));

    assert_swapped_merge_R7: assert property (@(posedge clk) disable iff (rst)
        swap |-> (merged_data[WIDTH-1:HALF] == rd_b_data[HALF-1:0] &&
                  merged_data[HALF-1:0]     == rd_a_data[WIDTH-1:HALF]));

    assert_same_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));
endmodule

bind dual_read_regfile rf_checker #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_a_addr   (rd_a_addr),
    .rd_b_addr   (rd_b_addr),
    .swap        (swap),
    .rd_a_data   (rd_a_data),
    .rd_b_data   (rd_b_data),
    .merged_data (merged_data)
);

// File: tb/dual_read_regfile_tb.sv
module dual_read_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_a_addr = '0;
    logic [3:0]  rd_b_addr = '0;
    logic        swap = 1'b0;
    logic [15:0] rd_a_data, rd_b_data, merged_data;

    int checks = 0;
    int failures = 0;
    int model [16];

    always #5 clk = ~clk;

    dual_read_regfile dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .swap(swap),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .merged_data(merged_data)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%04h expected=%04h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, compare against the model before the edge, then advance the model.
    task automatic cycle(input bit we, input int wa, input int wd, input int ra, input int rb,
                         input bit sw, input string tag);
        int hi_byte, lo_byte, exp_m;
        wr_en = we; wr_addr = 4'(wa); wr_data = 16'(wd);
        rd_a_addr = 4'(ra); rd_b_addr = 4'(rb); swap = sw;
        #2;
        if (!rst) begin
            hi_byte = (model[ra] >> 8) & 255;
            lo_byte = model[rb] & 255;
            exp_m = sw ? (lo_byte * 256 + hi_byte) : (hi_byte * 256 + lo_byte);
            check({tag, "/R9"}, "rd_a_data", int'(rd_a_data), model[ra]);
            check({tag, "/R9"}, "rd_b_data", int'(rd_b_data), model[rb]);
            check(sw ? {tag, "/R7"} : {tag, "/R6"}, "merged_data", int'(merged_data), exp_m);
        end
        @(posedge clk);
        if (rst) begin
            foreach (model[i]) model[i] = 0;
        end else if (we) begin
            model[wa] = wd & 16'hffff;
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        foreach (model[i]) model[i] = 16'hdead;
        @(negedge clk);
        // R1: a write asserted during reset must not survive.
        cycle(1'b1, 3, 16'h1234, 0, 0, 1'b0, "R1");
        cycle(1'b1, 7, 16'h5678, 0, 0, 1'b0, "R1");
        rst = 1'b0;
        for (int a = 0; a < 16; a++) cycle(1'b0, 0, 0, a, 15 - a, a[0], "R1");

        // R2 and R4: fill every word while reading other words.
        for (int a = 0; a < 16; a++)
            cycle(1'b1, a, (a * 16'h1111) ^ 16'h80c3, (a + 5) % 16, (a + 9) % 16, 1'b0, "R2/R4");
        for (int a = 0; a < 16; a++) cycle(1'b0, 0, 0, a, (a + 3) % 16, a[1], "R2");

        // R3: disabled writes with new data leave everything intact.
        for (int a = 0; a < 16; a++) cycle(1'b0, a, 16'hffff - a, a, a, 1'b0, "R3");
        for (int a = 0; a < 16; a++) cycle(1'b0, 0, 0, a, 15 - a, 1'b1, "R3");

        // R5: read of the word being written returns the old value, new value next cycle.
        cycle(1'b1, 6, 16'ha55a, 6, 6, 1'b0, "R5");
        cycle(1'b0, 0, 0, 6, 6, 1'b0, "R5");
        cycle(1'b1, 9, 16'h3c7e, 2, 9, 1'b1, "R5");
        cycle(1'b1, 9, 16'h0ff0, 9, 9, 1'b1, "R5");
        cycle(1'b0, 0, 0, 9, 2, 1'b0, "R5");

        // R6/R7: unaligned pair read both ways.
        cycle(1'b1, 10, 16'h11aa, 10, 11, 1'b0, "R6");
        cycle(1'b1, 11, 16'hbb22, 10, 11, 1'b0, "R6");
        cycle(1'b0, 0, 0, 10, 11, 1'b0, "R6");
        cycle(1'b0, 0, 0, 10, 11, 1'b1, "R7");
        cycle(1'b0, 0, 0, 11, 10, 1'b1, "R7");

        // R8: equal read addresses in both merge modes.
        for (int a = 0; a < 16; a++) begin
            cycle(1'b0, 0, 0, a, a, 1'b0, "R8");
            cycle(1'b0, 0, 0, a, a, 1'b1, "R8");
        end

        // Mixed traffic.
        for (int k = 0; k < 200; k++)
            cycle(k % 3 != 0, (k * 7) % 16, (k * 16'h9e37) & 16'hffff,
                  (k * 5) % 16, (k * 11) % 16, k[2], "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule